// File: doc/BRIEF.md
# Multichannel FIR Descriptor Sequencer

This block drives a time-shared FIR filter engine that serves a set of channels one after another. Each channel is described by a control block in memory. The sequencer walks those control blocks as a circular linked list. For each channel it fetches the block through a simple one-word memory port. It then starts the filter engine for one window with that channel's own tap count, window size and buffer pointers. When the engine reports completion, the sequencer writes the three updated buffer indices back into the control block and follows the chain pointer to the next channel.

The host programs the address of the first control block and a control word through a small write port. The control word carries an enable bit, a DMA-enable bit, an auto-repeat bit, a clear-flag bit and the number of channels per pass. After one pass over the configured channels the sequencer either stops and raises a halt flag for the host, or begins the next pass by itself. The multiply-accumulate datapath and the sample and coefficient transfers are outside the block and are seen only through a start/done handshake.

Top module: `fir_chain_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done_flag`, `pass_pulse`, `mem_req` and `eng_start` are all low.
- R2: A pass begins only when a control write (`host_sel`=0) has bit 0 (enable) and bit 1 (DMA enable) both set while the block is idle. A control write with either bit clear starts nothing and leaves `done_flag` unchanged.
- R3: A control block is 11 words read at base+0 through base+10 in increasing order, one word per `mem_ack`, with `mem_req`, `mem_we` and `mem_addr` held stable until acknowledged. Word 0 is the chain pointer, word 1 holds taps in [31:16] and window in [15:0], and buffer b (0 input, 1 coefficient, 2 output) has its index, modifier and length at words 2+3b, 3+3b and 4+3b.
- R4: After the read, `eng_start` pulses for one cycle with `eng_taps`, `eng_window` from word 1 and `eng_bufs` slice k equal to word 2+k.
- R5: After `eng_done`, the three slices of `eng_idx_upd` are written to base+2, base+5 and base+8, in that order, before any other access.
- R6: A pass starts at the address in the chain-start register (`host_sel`=1) and visits as many control blocks as the channel count (control bits [11:8]), each next block taken from word 0 of the current one.
- R7: A control block whose tap count or window size is zero gets no engine start and no write-back; its chain pointer is still followed.
- R8: With auto-repeat (control bit 2) clear, the block stops after the last channel of a pass: `pass_pulse` is high for one cycle, `done_flag` is set and `busy` drops.
- R9: With auto-repeat set, a new pass begins at the chain-start address with no host write, and every finished pass gives a `pass_pulse` and sets `done_flag`.
- R10: Clearing enable or DMA enable mid-pass stops the block after the current channel's write-back, with no further memory access and no pass pulse.
- R11: `done_flag` stays set until a control write with bit 3 set, or a write that starts a new pass, clears it.
- R12: A pass started with a channel count of zero finishes at once: `pass_pulse` and `done_flag` rise with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0: control word, 1: chain-start address |
| host_wdata | input | 32 | Host write data |
| busy | output | 1 | A pass is in progress |
| done_flag | output | 1 | Sticky pass-finished / halt flag |
| pass_pulse | output | 1 | One-cycle pulse at the end of each pass |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW (16) | Word address |
| mem_wdata | output | DW (32) | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | DW (32) | Read data |
| eng_start | output | 1 | Start one window on the filter engine |
| eng_taps | output | 16 | Tap count for the window |
| eng_window | output | 16 | Window size |
| eng_bufs | output | 9*DW | Index, modifier, length for the three buffers |
| eng_done | input | 1 | Engine finished the window |
| eng_idx_upd | input | 3*DW | Updated index for each buffer |

## Verification
The main sequence is tried with a six-channel ring that mixes 256-tap and 1024-tap channels, which shows that per-block parameters reach the engine unchanged and that the chain is followed to the end of the pass. A second run of the same ring with one zero-tap and one zero-window block separates skipping from stopping. A three-channel ring at another base in auto-repeat mode, stopped partway through its third pass, shows that new passes restart at the chain-start address and that a stop takes effect only at a channel boundary. Writes with DMA disabled and a zero channel count check the start and empty-pass cases.

// File: rtl/fir_seq_pkg.sv
// Shared constants and types for the FIR descriptor sequencer.
// Assumes word-addressed memory and a fixed 11-word control block.
package fir_seq_pkg;

    localparam int DESC_WORDS = 11;   // words per control block
    localparam int WIW        = 4;    // width of the word counter
    localparam int NBUF       = 3;    // input, coefficient, output buffers
    localparam int BIW        = 2;    // width of the buffer counter
    localparam int CHAIN_WORD = 0;    // offset of the chain pointer
    localparam int CFG_WORD   = 1;    // offset of the taps/window word
    localparam int IDX_BASE   = 2;    // offset of buffer 0's index word
    localparam int BUF_STRIDE = 3;    // index, modifier, length per buffer
    localparam int TW         = 16;   // tap count and window field width

    // control word bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_DMA     = 1;
    localparam int CTL_AUTO    = 2;
    localparam int CTL_CLR     = 3;
    localparam int CTL_CNT_LSB = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CHECK,
        S_ENGINE,
        S_WAIT,
        S_WRITE,
        S_NEXT
    } seq_state_t;

endpackage

// File: rtl/fir_seq_hostif.sv
// Host register file: control bits, channel count, chain-start address,
// start request and the sticky pass-finished flag.
// Assumes one host write per cycle at most.
module fir_seq_hostif
    import fir_seq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int HW  = 32,
    parameter int CHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_we,
    input  logic           host_sel,
    input  logic [HW-1:0]  host_wdata,
    input  logic           busy,
    input  logic           pass_done,
    output logic           go,
    output logic           run_ok,
    output logic           auto_it,
    output logic [CHW-1:0] chan_cnt,
    output logic [AW-1:0]  first_ptr,
    output logic           done_flag,
    output logic           pass_pulse
);

    logic en_q, dma_q;
    logic wr_ctl, wr_ptr, start_req;
    logic unused_hi;

    assign wr_ctl    = host_we && !host_sel;
    assign wr_ptr    = host_we &&  host_sel;
    assign start_req = wr_ctl && host_wdata[CTL_EN] && host_wdata[CTL_DMA]
                       && !busy && !go;
    assign run_ok    = en_q && dma_q;
    assign unused_hi = ^host_wdata[HW-1:AW];

    // Register host writes, the start request and the pass status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            dma_q      <= 1'b0;
            auto_it    <= 1'b0;
            chan_cnt   <= '0;
            first_ptr  <= '0;
            go         <= 1'b0;
            done_flag  <= 1'b0;
            pass_pulse <= 1'b0;
        end else begin
            go         <= start_req;
            pass_pulse <= pass_done;
            if (wr_ctl) begin
                en_q     <= host_wdata[CTL_EN];
                dma_q    <= host_wdata[CTL_DMA];
                auto_it  <= host_wdata[CTL_AUTO];
                chan_cnt <= host_wdata[CTL_CNT_LSB +: CHW];
            end
            if (wr_ptr) begin
                first_ptr <= host_wdata[AW-1:0];
            end
            if (pass_done) begin
                done_flag <= 1'b1;
            end else if (start_req || (wr_ctl && host_wdata[CTL_CLR])) begin
                done_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fir_seq_desc.sv
// Holds the words of the control block being processed and decodes
// the chain pointer, tap count, window size and buffer fields.
// Assumes DW >= 2*TW and DW >= AW.
module fir_seq_desc
    import fir_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              word_we,
    input  logic [WIW-1:0]                    word_idx,
    input  logic [DW-1:0]                     word_data,
    output logic [AW-1:0]                     chain_ptr,
    output logic [TW-1:0]                     taps,
    output logic [TW-1:0]                     window,
    output logic                              cfg_empty,
    output logic [NBUF*BUF_STRIDE*DW-1:0]     bufs
);

    localparam int NFIELD = NBUF * BUF_STRIDE;

    logic [DW-1:0] words [DESC_WORDS];
    logic          unused_chain;

    for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
        // Capture word i of the control block when it arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (word_we && word_idx == WIW'(i)) begin
                words[i] <= word_data;
            end
        end
    end

    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        assign bufs[k*DW +: DW] = words[IDX_BASE + k];
    end

    assign chain_ptr    = words[CHAIN_WORD][AW-1:0];
    assign taps         = words[CFG_WORD][2*TW-1:TW];
    assign window       = words[CFG_WORD][TW-1:0];
    assign cfg_empty    = (taps == '0) || (window == '0);
    assign unused_chain = ^words[CHAIN_WORD][DW-1:AW] ^ ^words[CFG_WORD][DW-1:2*TW];

endmodule

// File: rtl/fir_seq_ctrl.sv
// Pass sequencer: walks the control-block ring, drives the memory port
// for fetch and write-back, and starts the filter engine per channel.
// Assumes one outstanding memory access; read data arrives with mem_ack.
module fir_seq_ctrl
    import fir_seq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int CHW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               run_ok,
    input  logic               auto_it,
    input  logic [CHW-1:0]     chan_cnt,
    input  logic [AW-1:0]      first_ptr,
    input  logic [AW-1:0]      chain_ptr,
    input  logic               cfg_empty,
    input  logic               eng_done,
    input  logic [NBUF*DW-1:0] eng_idx_upd,
    input  logic               mem_ack,
    output logic               word_we,
    output logic [WIW-1:0]     word_idx,
    output logic               busy,
    output logic               pass_done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic               eng_start
);

    seq_state_t         state;
    logic [AW-1:0]      base;
    logic [WIW-1:0]     word;
    logic [BIW-1:0]     wb;
    logic [CHW-1:0]     ch;
    logic [CHW-1:0]     cnt_q;
    logic [NBUF*DW-1:0] upd_q;
    logic               last_ch;
    logic [AW-1:0]      wb_off;

    assign last_ch   = (ch == cnt_q - CHW'(1));
    assign wb_off    = AW'(IDX_BASE + BUF_STRIDE * int'(wb));
    assign busy      = (state != S_IDLE);
    assign mem_req   = (state == S_READ) || (state == S_WRITE);
    assign mem_we    = (state == S_WRITE);
    assign mem_addr  = base + ((state == S_WRITE) ? wb_off : AW'(word));
    assign mem_wdata = upd_q[int'(wb)*DW +: DW];
    assign eng_start = (state == S_ENGINE);
    assign word_we   = (state == S_READ) && mem_ack;
    assign word_idx  = word;
    assign pass_done = ((state == S_IDLE) && go && (chan_cnt == '0))
                       || ((state == S_NEXT) && last_ch);

    // Advance the per-channel sequence and the ring position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            base  <= '0;
            word  <= '0;
            wb    <= '0;
            ch    <= '0;
            cnt_q <= '0;
            upd_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (go && chan_cnt != '0) begin
                        base  <= first_ptr;
                        cnt_q <= chan_cnt;
                        ch    <= '0;
                        word  <= '0;
                        state <= S_READ;
                    end
                end
                S_READ: begin
                    if (mem_ack) begin
                        if (word == WIW'(DESC_WORDS - 1)) begin
                            state <= S_CHECK;
                        end else begin
                            word <= word + WIW'(1);
                        end
                    end
                end
                S_CHECK: begin
                    state <= cfg_empty ? S_NEXT : S_ENGINE;
                end
                S_ENGINE: begin
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (eng_done) begin
                        upd_q <= eng_idx_upd;
                        wb    <= '0;
                        state <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (mem_ack) begin
                        if (wb == BIW'(NBUF - 1)) begin
                            state <= S_NEXT;
                        end else begin
                            wb <= wb + BIW'(1);
                        end
                    end
                end
                S_NEXT: begin
                    word <= '0;
                    if (last_ch) begin
                        ch    <= '0;
                        base  <= first_ptr;
                        state <= (auto_it && run_ok) ? S_READ : S_IDLE;
                    end else begin
                        ch    <= ch + CHW'(1);
                        base  <= chain_ptr;
                        state <= run_ok ? S_READ : S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fir_chain_seq.sv
// Top of the multichannel FIR descriptor sequencer: host registers,
// control-block holder and pass sequencer.
// Assumes the memory and the filter engine follow the start/done and
// request/ack handshakes described in the brief.
module fir_chain_seq
    import fir_seq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int CHW = 4,
    parameter int HW  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic                          host_sel,
    input  logic [HW-1:0]                 host_wdata,
    output logic                          busy,
    output logic                          done_flag,
    output logic                          pass_pulse,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    input  logic                          mem_ack,
    input  logic [DW-1:0]                 mem_rdata,
    output logic                          eng_start,
    output logic [TW-1:0]                 eng_taps,
    output logic [TW-1:0]                 eng_window,
    output logic [NBUF*BUF_STRIDE*DW-1:0] eng_bufs,
    input  logic                          eng_done,
    input  logic [NBUF*DW-1:0]            eng_idx_upd
);

    logic           go, run_ok, auto_it, pass_done;
    logic [CHW-1:0] chan_cnt;
    logic [AW-1:0]  first_ptr, chain_ptr;
    logic           cfg_empty, word_we;
    logic [WIW-1:0] word_idx;

    fir_seq_hostif #(.AW(AW), .HW(HW), .CHW(CHW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .busy(busy), .pass_done(pass_done),
        .go(go), .run_ok(run_ok), .auto_it(auto_it), .chan_cnt(chan_cnt),
        .first_ptr(first_ptr), .done_flag(done_flag), .pass_pulse(pass_pulse)
    );

    fir_seq_desc #(.AW(AW), .DW(DW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .word_we(word_we), .word_idx(word_idx), .word_data(mem_rdata),
        .chain_ptr(chain_ptr), .taps(eng_taps), .window(eng_window),
        .cfg_empty(cfg_empty), .bufs(eng_bufs)
    );

    fir_seq_ctrl #(.AW(AW), .DW(DW), .CHW(CHW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .go(go), .run_ok(run_ok), .auto_it(auto_it), .chan_cnt(chan_cnt),
        .first_ptr(first_ptr), .chain_ptr(chain_ptr), .cfg_empty(cfg_empty),
        .eng_done(eng_done), .eng_idx_upd(eng_idx_upd), .mem_ack(mem_ack),
        .word_we(word_we), .word_idx(word_idx), .busy(busy),
        .pass_done(pass_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .eng_start(eng_start)
    );

endmodule

// File: rtl/fir_chain_seq_chk.sv
// Protocol checker for the descriptor sequencer, bound to the top.
module fir_chain_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done_flag,
    input logic          pass_pulse,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          eng_start
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R4

    AST_START_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !mem_req); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !eng_start); // R1

    AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pass_pulse |-> done_flag); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_pulse |=> !pass_pulse); // R9

endmodule

bind fir_chain_seq fir_chain_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_flag(done_flag),
    .pass_pulse(pass_pulse), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .eng_start(eng_start)
);

// File: tb/fir_chain_seq_test.sv
`timescale 1ns/1ps
module fir_chain_seq_test;

    localparam int AW = 16, DW = 32, CHW = 4, NB = 3, NF = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0, host_sel = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic              busy, done_flag, pass_pulse;
    logic              mem_req, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DW-1:0]     mem_rdata = '0;
    logic              eng_start;
    logic [15:0]       eng_taps, eng_window;
    logic [NF*DW-1:0]  eng_bufs;
    logic              eng_done = 1'b0;
    logic [NB*DW-1:0]  eng_idx_upd = '0;

    always #2 clk = ~clk;   // 250 MHz

    fir_chain_seq uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .done_flag(done_flag),
        .pass_pulse(pass_pulse), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_taps(eng_taps),
        .eng_window(eng_window), .eng_bufs(eng_bufs), .eng_done(eng_done),
        .eng_idx_upd(eng_idx_upd)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { bit we; int addr; logic [31:0] data; } mtx_t;
    typedef struct { int taps; int win; logic [NF*DW-1:0] bufs; } etx_t;
    mtx_t exp_mem[$];
    etx_t exp_eng[$];
    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];
    int exp_pulses = 0;

    function automatic logic [31:0] next_idx(logic [31:0] idx, logic [31:0] md,
                                             logic [31:0] len, int win);
        return (idx + win * md) % len;
    endfunction

    task automatic put_word(int a, logic [31:0] d);
        mem[a] = d; ref_mem[a] = d;
    endtask

    task automatic make_desc(int a, int nxt, int taps, int win, int seed);
        put_word(a, nxt);
        put_word(a + 1, {taps[15:0], win[15:0]});
        for (int b = 0; b < NB; b++) begin
            put_word(a + 2 + 3*b, seed + b);
            put_word(a + 3 + 3*b, b + 1);
            put_word(a + 4 + 3*b, 40 + 5*b + seed);
        end
    endtask

    // Predict the access sequence; stop_win > 0 ends after that window.
    task automatic model_run(int first, int cnt, int passes, int stop_win);
        int wins = 0;
        for (int p = 0; p < passes; p++) begin
            int base = first;
            for (int c = 0; c < cnt; c++) begin
                int taps, win, nxt;
                for (int w = 0; w < 11; w++)
                    exp_mem.push_back('{1'b0, base + w, ref_mem[base + w]});
                taps = int'(ref_mem[base + 1][31:16]);
                win  = int'(ref_mem[base + 1][15:0]);
                nxt  = int'(ref_mem[base][7:0]);
                if (taps != 0 && win != 0) begin
                    etx_t e;
                    e.taps = taps; e.win = win;
                    for (int k = 0; k < NF; k++) e.bufs[k*DW +: DW] = ref_mem[base + 2 + k];
                    exp_eng.push_back(e);
                    for (int b = 0; b < NB; b++) begin
                        logic [31:0] v;
                        v = next_idx(ref_mem[base+2+3*b], ref_mem[base+3+3*b],
                                     ref_mem[base+4+3*b], win);
                        ref_mem[base + 2 + 3*b] = v;
                        exp_mem.push_back('{1'b1, base + 2 + 3*b, v});
                    end
                    wins++;
                    if (wins == stop_win && c != cnt - 1) return;
                end
                base = nxt;
            end
            exp_pulses++;
        end
    endtask

    // ---------------- memory responder and monitor ----------------
    int tx_count = 0;
    always @(negedge clk) begin : mem_side
        mtx_t e;
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            tx_count++;
            if (exp_mem.size() == 0) begin
                check(1'b0, "R10", "unexpected memory access", longint'(mem_addr), 0);
            end else begin
                e = exp_mem.pop_front();
                check(mem_we == e.we && mem_addr == e.addr[AW-1:0], e.we ? "R5" : "R3",
                      "access kind/address", longint'({mem_we, mem_addr}),
                      longint'({e.we, e.addr[15:0]}));
                if (mem_we) check(mem_wdata == e.data, "R5", "write-back value",
                                  longint'(mem_wdata), longint'(e.data));
            end
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[7:0]];
            mem_ack = 1'b1;
        end
    end

    // ---------------- filter engine responder ----------------
    int eng_seen = 0, eng_dn = 0;
    always @(negedge clk) begin : eng_side
        etx_t e;
        if (eng_done) eng_done = 1'b0;
        if (rst_n && eng_start) begin
            eng_seen++;
            if (exp_eng.size() == 0) begin
                check(1'b0, "R7", "unexpected engine start", 1, 0);
            end else begin
                e = exp_eng.pop_front();
                check(eng_taps == e.taps[15:0], "R4", "tap count", eng_taps, e.taps);
                check(eng_window == e.win[15:0], "R4", "window", eng_window, e.win);
                for (int k = 0; k < NF; k++)
                    check(eng_bufs[k*DW +: DW] == e.bufs[k*DW +: DW], "R4", "buffer field",
                          longint'(eng_bufs[k*DW +: DW]), longint'(e.bufs[k*DW +: DW]));
            end
            for (int b = 0; b < NB; b++)
                eng_idx_upd[b*DW +: DW] = next_idx(eng_bufs[(3*b)*DW +: DW],
                    eng_bufs[(3*b+1)*DW +: DW], eng_bufs[(3*b+2)*DW +: DW], int'(eng_window));
            eng_dn = 4;
        end else if (eng_dn > 0) begin
            eng_dn--;
            if (eng_dn == 0) eng_done = 1'b1;
        end
    end

    int pulses = 0;
    always @(negedge clk) begin : pulse_side
        if (rst_n && pass_pulse) begin
            pulses++;
            check(done_flag, "R8", "flag with pass pulse", done_flag, 1);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !finished) begin
            finished = 1'b1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] ctl(bit en, bit dma, bit aut, bit clr, int cnt);
        return {20'd0, cnt[3:0], 4'd0, clr, aut, dma, en};
    endfunction

    task automatic host_write(bit sel, logic [31:0] d);
        host_sel = sel; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int tx0, p0, e0;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done_flag && !pass_pulse, "R1", "idle status after reset",
              {busy, done_flag, pass_pulse}, 0);
        check(!mem_req && !eng_start, "R1", "no request after reset",
              {mem_req, eng_start}, 0);

        // six-channel ring, mixed tap counts, single pass
        for (int c = 0; c < 6; c++)
            make_desc(16 + 16*c, 16 + 16*((c + 1) % 6), (c < 4) ? 256 : 1024, 128, c + 1);
        host_write(1'b1, 32'd16);
        model_run(16, 6, 1, 0);
        p0 = pulses;
        host_write(1'b0, ctl(1, 1, 0, 0, 6));
        wait_idle();
        check(exp_mem.size() == 0, "R6", "ring fully walked", exp_mem.size(), 0);
        check(exp_eng.size() == 0, "R4", "all windows started", exp_eng.size(), 0);
        check(pulses == p0 + 1, "R8", "one pass pulse", pulses - p0, 1);
        check(done_flag && !busy, "R8", "halted with flag", {done_flag, busy}, 2);

        // DMA disabled: no start, flag untouched
        tx0 = tx_count;
        host_write(1'b0, ctl(1, 0, 0, 0, 6));
        repeat (10) @(negedge clk);
        check(!busy && tx_count == tx0, "R2", "no start without DMA enable",
              tx_count - tx0, 0);
        check(done_flag, "R2", "flag kept on non-starting write", done_flag, 1);
        host_write(1'b0, ctl(0, 0, 0, 1, 6));
        @(negedge clk);
        check(!done_flag, "R11", "flag cleared by clear bit", done_flag, 0);

        // skip a zero-tap and a zero-window block
        put_word(48 + 1, {16'd0, 16'd128});
        put_word(80 + 1, {16'd256, 16'd0});
        model_run(16, 6, 1, 0);
        e0 = eng_seen;
        host_write(1'b0, ctl(1, 1, 0, 0, 6));
        wait_idle();
        check(eng_seen - e0 == 4, "R7", "windows run with two skipped", eng_seen - e0, 4);
        check(exp_mem.size() == 0, "R7", "skipped blocks still chained", exp_mem.size(), 0);
        check(done_flag, "R11", "flag set again at pass end", done_flag, 1);
        host_write(1'b0, ctl(1, 1, 0, 0, 6));
        @(negedge clk);
        check(!done_flag, "R11", "flag cleared by new start", done_flag, 0);
        model_run(16, 6, 1, 0);
        wait_idle();
        check(exp_mem.size() == 0, "R6", "third pass sequence", exp_mem.size(), 0);

        // auto-repeat over a three-block ring, stopped mid third pass
        for (int c = 0; c < 3; c++)
            make_desc(128 + 16*c, 128 + 16*((c + 1) % 3), 64 + c, 32 + 8*c, c + 3);
        host_write(1'b1, 32'd128);
        model_run(128, 3, 3, 8);
        p0 = pulses; e0 = eng_seen;
        host_write(1'b0, ctl(1, 1, 1, 0, 3));
        while (pulses < p0 + 1) @(negedge clk);
        @(negedge clk);
        check(busy, "R9", "continues after first pass", busy, 1);
        while (eng_seen < e0 + 8) @(negedge clk);
        host_write(1'b0, ctl(0, 1, 1, 0, 3));
        wait_idle();
        check(exp_mem.size() == 0, "R10", "stop after current write-back", exp_mem.size(), 0);
        check(pulses - p0 == 2, "R9", "pulse per finished pass", pulses - p0, 2);
        check(done_flag, "R9", "flag set in repeat mode", done_flag, 1);

        // zero channel count
        host_write(1'b0, ctl(0, 0, 0, 1, 0));
        tx0 = tx_count; p0 = pulses;
        host_write(1'b0, ctl(1, 1, 0, 0, 0));
        repeat (6) @(negedge clk);
        check(pulses - p0 == 1 && done_flag, "R12", "empty pass completes",
              {pulses - p0, done_flag}, 3);
        check(tx_count == tx0 && !busy, "R12", "empty pass has no traffic", tx_count - tx0, 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule